// File: doc/BRIEF.md
# I2C Target Register Interface for an 8-Line GPIO Port

This block is an I2C/SMBus target that gives a bus master access to four byte-wide registers controlling an 8-line general-purpose port. It samples the bus clock and data lines into its own system clock domain. It pulls the data line low through a single enable output, which models an open-drain pad. The target address has a fixed upper nibble, and its three low bits come from strap pins.

A master writes by addressing the target with the write flag, sending a command byte that becomes the register pointer, and then sending data bytes. Every data byte lands in the same register, because the pointer never advances. To read, the master sets the pointer in a write phase, issues a repeated start and addresses the target again with the read flag. The pointer survives both the repeated start and the stop that ends a transfer. The target then returns the selected register once for every byte the master acknowledges. The port input is captured anew for each byte.

An active-low interrupt flags changes on pins configured as inputs. It is released when the input register is loaded for transmission.

Top module: `i2c_gpio_expander`

## Requirements
- R1: The target answers only the 7-bit address formed by binary 0111 followed by the three strap bits, with the R/W flag as the eighth bit (0 = write, 1 = read). On any other address it acknowledges nothing and leaves SDA released until the next start.
- R2: In a write transfer the first byte after the address is stored as the register pointer, and each following byte is written to the register it selects. The target acknowledges the address, the command and every data byte.
- R3: The pointer never auto-increments. Several data bytes in one write all go to the same register, and a read returns the same register for every byte the master acknowledges.
- R4: Register map by pointer value: 00h reads the synchronised pins XOR the inversion register and ignores writes; 01h is the pin drive value; 02h is the inversion register; 03h is the direction register, where a bit set to 1 makes that pin an input.
- R5: A pointer value above 03h is acknowledged but leaves every register unchanged on write, and it reads as 00h.
- R6: After reset the drive register is FFh, the inversion register is 00h, the direction register is FFh (all pins inputs), the pointer is 00h and the interrupt output is high.
- R7: The pointer keeps its value across a repeated start and across transfers. A read with no command byte returns the register selected last, which is the input register after reset.
- R8: When the master does not acknowledge a read byte, the target releases SDA and drives no further bits until the next start.
- R9: A stop condition at any point returns the target to idle with SDA released. A data byte that is cut short by a stop is not written.
- R10: The value sent in each read byte is captured at the rising SCL edge of the acknowledge clock that precedes it (the address acknowledge, or the master acknowledge of the previous byte). A pin change after that edge appears in the next byte.
- R11: The interrupt output goes low when a pin configured as an input changes. It returns high when the input register is loaded for transmission. Changes on pins configured as outputs and reads of other registers leave it unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scl_i | input | 1 | Bus clock line as seen at the pad |
| sda_i | input | 1 | Bus data line as seen at the pad |
| sda_pull_o | output | 1 | High pulls SDA low (open-drain enable) |
| strap_i | input | 3 | Low three bits of the target address |
| pin_i | input | 8 | Port pin levels |
| pin_drive_o | output | 8 | Drive register value for the pins |
| pin_is_input_o | output | 8 | Direction register; 1 = pin is an input |
| irq_n_o | output | 1 | Active-low input-change interrupt |

## Verification
The bench builds the block with its default two-stage synchronisers and fixed nibble 0111, and it ties the straps to 101, so the target answers at 3Dh. An address of 3Ch then differs from the target only in a strap-derived bit, which exercises the strap comparison directly. A bus quarter-period of ten system clocks gives the two-flop sync path enough margin that SDA setup, the acknowledge-edge capture and pin changes in the middle of a byte can all be placed on known cycles.

// File: rtl/gpx_pkg.sv
`timescale 1ns/1ps
package gpx_pkg;

  localparam int BYTE_W  = 8;
  localparam int STRAP_W = 3;
  localparam int FIXED_W = 4;

  localparam logic [BYTE_W-1:0] REG_IN  = 8'h00;
  localparam logic [BYTE_W-1:0] REG_OUT = 8'h01;
  localparam logic [BYTE_W-1:0] REG_POL = 8'h02;
  localparam logic [BYTE_W-1:0] REG_CFG = 8'h03;

  typedef enum logic [3:0] {
    PH_IDLE, PH_ADDR, PH_AACK, PH_CMD, PH_CACK,
    PH_WDATA, PH_WACK, PH_RDATA, PH_MACK
  } phase_e;

  typedef struct packed {
    logic [BYTE_W-1:0] drive;
    logic [BYTE_W-1:0] invert;
    logic [BYTE_W-1:0] dir;
  } regs_t;

  // Address frame: seven address bits then the R/W flag in bit 0.
  function automatic logic frame_hits(input logic [BYTE_W-1:0] frame,
                                      input logic [FIXED_W-1:0] fixed,
                                      input logic [STRAP_W-1:0] strap);
    return frame[BYTE_W-1:1] == {fixed, strap};
  endfunction

  function automatic logic [BYTE_W-1:0] reg_view(input logic [BYTE_W-1:0] sel,
                                                 input logic [BYTE_W-1:0] pins,
                                                 input regs_t r);
    case (sel)
      REG_IN:  return pins ^ r.invert;
      REG_OUT: return r.drive;
      REG_POL: return r.invert;
      REG_CFG: return r.dir;
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/gpx_sync.sv
`timescale 1ns/1ps
module gpx_sync #(
  parameter int W = 1,
  parameter int STAGES = 2,
  parameter logic [W-1:0] RST_VAL = '0
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);

  if (STAGES <= 1) begin : g_single
    logic [W-1:0] r;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) r <= RST_VAL;
      else        r <= d;
    end
    assign q = r;
  end else begin : g_chain
    logic [STAGES-1:0][W-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= {STAGES{RST_VAL}};
      else        chain <= {chain[STAGES-2:0], d};
    end
    assign q = chain[STAGES-1];
  end

endmodule

// File: rtl/gpx_i2c_target.sv
`timescale 1ns/1ps
module gpx_i2c_target
  import gpx_pkg::*;
#(
  parameter logic [FIXED_W-1:0] ADDR_FIXED = 4'b0111
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_s,
  input  logic              sda_s,
  input  logic [STRAP_W-1:0] strap,
  input  logic [BYTE_W-1:0] rd_data,
  output logic              sda_oe,
  output logic [BYTE_W-1:0] ptr,
  output logic              wr_en,
  output logic [BYTE_W-1:0] wr_data,
  output logic              rd_take
);

  localparam int CNT_W = $clog2(BYTE_W + 1);
  localparam logic [CNT_W-1:0] LAST_BIT = CNT_W'(BYTE_W - 1);
  localparam logic [CNT_W-1:0] FULL     = CNT_W'(BYTE_W);

  logic scl_q, sda_q;
  phase_e st;
  logic [CNT_W-1:0] bitcnt;
  logic [BYTE_W-1:0] shreg, txreg;
  logic rw, acked;

  // Named bus events for the assertions and the phase machine.
  logic ev_start, ev_stop, ev_rise, ev_fall, byte_full, hit;
  assign ev_start  = scl_s & scl_q & sda_q & ~sda_s;
  assign ev_stop   = scl_s & scl_q & ~sda_q & sda_s;
  assign ev_rise   = scl_s & ~scl_q;
  assign ev_fall   = ~scl_s & scl_q;
  assign byte_full = (bitcnt == FULL);
  assign hit       = frame_hits(shreg, ADDR_FIXED, strap);

  assign rd_take = ev_rise & (((st == PH_AACK) & rw) | ((st == PH_MACK) & ~sda_s));
  assign wr_en   = (st == PH_WDATA) & ev_fall & byte_full;
  assign wr_data = shreg;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q <= 1'b1;
      sda_q <= 1'b1;
    end else begin
      scl_q <= scl_s;
      sda_q <= sda_s;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= PH_IDLE;
      bitcnt <= '0;
      shreg  <= '0;
      txreg  <= '0;
      sda_oe <= 1'b0;
      ptr    <= REG_IN;
      rw     <= 1'b0;
      acked  <= 1'b0;
    end else if (ev_start) begin
      st     <= PH_ADDR;
      bitcnt <= '0;
      sda_oe <= 1'b0;
    end else if (ev_stop) begin
      st     <= PH_IDLE;
      sda_oe <= 1'b0;
    end else begin
      if (rd_take) txreg <= rd_data;
      case (st)
        PH_ADDR, PH_CMD, PH_WDATA: begin
          if (ev_rise && !byte_full) begin
            shreg  <= {shreg[BYTE_W-2:0], sda_s};
            bitcnt <= bitcnt + 1'b1;
          end else if (ev_fall && byte_full) begin
            bitcnt <= '0;
            if (st == PH_ADDR) begin
              if (hit) begin
                sda_oe <= 1'b1;
                rw     <= shreg[0];
                st     <= PH_AACK;
              end else begin
                st <= PH_IDLE;
              end
            end else if (st == PH_CMD) begin
              ptr    <= shreg;
              sda_oe <= 1'b1;
              st     <= PH_CACK;
            end else begin
              sda_oe <= 1'b1;
              st     <= PH_WACK;
            end
          end
        end
        PH_AACK: begin
          if (ev_fall) begin
            if (rw) begin
              sda_oe <= ~txreg[BYTE_W-1];
              st     <= PH_RDATA;
            end else begin
              sda_oe <= 1'b0;
              st     <= PH_CMD;
            end
          end
        end
        PH_CACK, PH_WACK: begin
          if (ev_fall) begin
            sda_oe <= 1'b0;
            st     <= PH_WDATA;
          end
        end
        PH_RDATA: begin
          if (ev_fall) begin
            if (bitcnt == LAST_BIT) begin
              sda_oe <= 1'b0;
              bitcnt <= '0;
              st     <= PH_MACK;
            end else begin
              sda_oe <= ~txreg[BYTE_W-2];
              txreg  <= {txreg[BYTE_W-2:0], 1'b0};
              bitcnt <= bitcnt + 1'b1;
            end
          end
        end
        PH_MACK: begin
          if (ev_rise) acked <= ~sda_s;
          if (ev_fall) begin
            if (acked) begin
              sda_oe <= ~txreg[BYTE_W-1];
              st     <= PH_RDATA;
            end else begin
              st <= PH_IDLE;
            end
          end
        end
        default: ;
      endcase
    end
  end

  assert_miss_silent_R1: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_ADDR && ev_fall && byte_full && !hit && !ev_start && !ev_stop) |=> !sda_oe);

  assert_restart_keeps_ptr_R7: assert property (@(posedge clk) disable iff (!rst_n)
    ev_start |=> $stable(ptr));

  assert_nack_release_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (st == PH_MACK && ev_fall && !acked && !ev_start && !ev_stop) |=> !sda_oe);

  assert_stop_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    ev_stop |=> (!sda_oe && st == PH_IDLE));

endmodule

// File: rtl/gpx_regfile.sv
`timescale 1ns/1ps
module gpx_regfile
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BYTE_W-1:0] pin_s,
  input  logic [BYTE_W-1:0] ptr,
  input  logic              wr_en,
  input  logic [BYTE_W-1:0] wr_data,
  input  logic              rd_take,
  output logic [BYTE_W-1:0] rd_data,
  output regs_t             regs,
  output logic              irq_n
);

  localparam int WARM_MAX = SYNC_STAGES + 1;
  localparam int WARM_W   = $clog2(WARM_MAX + 1);

  logic [WARM_W-1:0] warm;
  logic primed;
  logic [BYTE_W-1:0] pin_prev;
  logic irq_set, irq_clr, irq_flag;

  assign primed  = (warm == WARM_W'(WARM_MAX));
  assign irq_set = primed & (|((pin_s ^ pin_prev) & regs.dir));
  assign irq_clr = rd_take & (ptr == REG_IN);
  assign rd_data = reg_view(ptr, pin_s, regs);
  assign irq_n   = ~irq_flag;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      regs.drive  <= '1;
      regs.invert <= '0;
      regs.dir    <= '1;
    end else if (wr_en) begin
      case (ptr)
        REG_OUT: regs.drive  <= wr_data;
        REG_POL: regs.invert <= wr_data;
        REG_CFG: regs.dir    <= wr_data;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      warm     <= '0;
      pin_prev <= '0;
      irq_flag <= 1'b0;
    end else begin
      if (!primed) warm <= warm + 1'b1;
      pin_prev <= pin_s;
      if (irq_set)      irq_flag <= 1'b1;
      else if (irq_clr) irq_flag <= 1'b0;
    end
  end

  assert_regs_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs));

  assert_range_ignored_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && ptr > REG_CFG) |=> $stable(regs));

  assert_irq_raise_R11: assert property (@(posedge clk) disable iff (!rst_n)
    irq_set |=> !irq_n);

  assert_irq_release_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (irq_clr && !irq_set) |=> irq_n);

endmodule

// File: rtl/i2c_gpio_expander.sv
`timescale 1ns/1ps
module i2c_gpio_expander
  import gpx_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter logic [FIXED_W-1:0] ADDR_FIXED = 4'b0111
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               scl_i,
  input  logic               sda_i,
  output logic               sda_pull_o,
  input  logic [STRAP_W-1:0] strap_i,
  input  logic [BYTE_W-1:0]  pin_i,
  output logic [BYTE_W-1:0]  pin_drive_o,
  output logic [BYTE_W-1:0]  pin_is_input_o,
  output logic               irq_n_o
);

  logic [1:0] bus_s;
  logic [BYTE_W-1:0] pin_s, ptr, wr_data, rd_data;
  logic wr_en, rd_take;
  regs_t regs;

  gpx_sync #(.W(2), .STAGES(SYNC_STAGES), .RST_VAL(2'b11)) u_bus_sync (
    .clk(clk), .rst_n(rst_n), .d({scl_i, sda_i}), .q(bus_s));

  gpx_sync #(.W(BYTE_W), .STAGES(SYNC_STAGES), .RST_VAL('0)) u_pin_sync (
    .clk(clk), .rst_n(rst_n), .d(pin_i), .q(pin_s));

  gpx_i2c_target #(.ADDR_FIXED(ADDR_FIXED)) u_target (
    .clk(clk), .rst_n(rst_n), .scl_s(bus_s[1]), .sda_s(bus_s[0]),
    .strap(strap_i), .rd_data(rd_data), .sda_oe(sda_pull_o), .ptr(ptr),
    .wr_en(wr_en), .wr_data(wr_data), .rd_take(rd_take));

  gpx_regfile #(.SYNC_STAGES(SYNC_STAGES)) u_regs (
    .clk(clk), .rst_n(rst_n), .pin_s(pin_s), .ptr(ptr), .wr_en(wr_en),
    .wr_data(wr_data), .rd_take(rd_take), .rd_data(rd_data), .regs(regs),
    .irq_n(irq_n_o));

  assign pin_drive_o    = regs.drive;
  assign pin_is_input_o = regs.dir;

endmodule

// File: tb/i2c_gpio_expander_test.sv
`timescale 1ns/1ps
module i2c_gpio_expander_test;

  localparam int Q = 10;
  localparam logic [7:0] AW = 8'h7A;   // 3Dh, write
  localparam logic [7:0] AR = 8'h7B;   // 3Dh, read

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl = 1'b1;
  logic m_low = 1'b0;
  logic [7:0] pins = 8'h5A;
  logic sda_pull, irq_n;
  logic [7:0] drv, isin;
  wire sda_bus = ~(m_low | sda_pull);

  int vectors = 0;
  int miscompares = 0;
  bit finished = 1'b0;

  typedef struct { logic [7:0] v; string tag; } exp_t;
  exp_t sb_q[$];
  event got_ev;
  logic [7:0] got_v;

  always #2.5 clk = ~clk;

  i2c_gpio_expander uut (
    .clk(clk), .rst_n(rst_n), .scl_i(scl), .sda_i(sda_bus),
    .sda_pull_o(sda_pull), .strap_i(3'b101), .pin_i(pins),
    .pin_drive_o(drv), .pin_is_input_o(isin), .irq_n_o(irq_n));

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    vectors++;
    if (act !== exp) begin
      miscompares++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  task automatic half();
    repeat (Q) @(negedge clk);
  endtask

  task automatic bus_start();
    m_low = 1'b0; half(); scl = 1'b1; half();
    m_low = 1'b1; half(); scl = 1'b0; half();
  endtask

  task automatic bus_stop();
    m_low = 1'b1; half(); scl = 1'b1; half();
    m_low = 1'b0; half(); half();
  endtask

  task automatic send_bit(input logic b);
    m_low = ~b; half(); scl = 1'b1; half(); half(); scl = 1'b0; half();
  endtask

  task automatic send_byte(input logic [7:0] v, input logic exp_ack, input string tag);
    logic ack;
    for (int i = 7; i >= 0; i--) send_bit(v[i]);
    m_low = 1'b0; half(); scl = 1'b1; half();
    ack = sda_bus; half(); scl = 1'b0; half();
    chk(tag, {7'd0, ack}, {7'd0, exp_ack});
  endtask

  // Driver side: push the expected byte, then clock it in.
  task automatic recv_byte(input logic [7:0] exp, input string tag, input logic master_ack);
    logic [7:0] v;
    sb_q.push_back('{v: exp, tag: tag});
    m_low = 1'b0;
    for (int i = 7; i >= 0; i--) begin
      half(); scl = 1'b1; half(); v[i] = sda_bus; half(); scl = 1'b0;
    end
    m_low = master_ack; half(); scl = 1'b1; half(); half(); scl = 1'b0; half();
    m_low = 1'b0;
    got_v = v;
    -> got_ev;
  endtask

  task automatic write_reg(input logic [7:0] cmd, input logic [7:0] d, input string tag);
    bus_start();
    send_byte(AW, 1'b0, {tag, " addr ack"});
    send_byte(cmd, 1'b0, {tag, " cmd ack"});
    send_byte(d, 1'b0, {tag, " data ack"});
    bus_stop();
  endtask

  task automatic read_reg(input logic [7:0] cmd, input int n, input logic [7:0] exp, input string tag);
    bus_start();
    send_byte(AW, 1'b0, {tag, " addr ack"});
    send_byte(cmd, 1'b0, {tag, " cmd ack"});
    bus_start();
    send_byte(AR, 1'b0, {tag, " read addr ack"});
    for (int i = 0; i < n; i++) recv_byte(exp, tag, (i != n - 1));
    bus_stop();
  endtask

  // Monitor side: pop and compare each byte the bus delivers.
  initial begin
    forever begin
      exp_t e;
      @(got_ev);
      if (sb_q.size() == 0) begin
        vectors++;
        miscompares++;
        $display("FAIL R3 unexpected byte: actual %02h expected none", got_v);
      end else begin
        e = sb_q.pop_front();
        chk(e.tag, got_v, e.v);
      end
    end
  end

  initial begin
    repeat (180000) @(posedge clk);
    if (!finished) begin
      vectors++;
      miscompares++;
      $display("FAIL watchdog: actual hung expected done");
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (20) @(negedge clk);
    chk("R6 drive reset", drv, 8'hFF);
    chk("R6 direction reset", isin, 8'hFF);
    chk("R6 irq reset", {7'd0, irq_n}, 8'h01);
    chk("R6 sda idle", {7'd0, sda_pull}, 8'h00);

    // R7: no command yet, pointer is the input register
    bus_start();
    send_byte(AR, 1'b0, "R1 match ack");
    recv_byte(8'h5A, "R7 default pointer", 1'b0);
    bus_stop();
    read_reg(8'h01, 1, 8'hFF, "R6 drive via bus");
    read_reg(8'h02, 1, 8'h00, "R6 inversion via bus");
    read_reg(8'h03, 1, 8'hFF, "R6 direction via bus");

    // R1: strap bit mismatch
    bus_start();
    send_byte(8'h78, 1'b1, "R1 wrong address no ack");
    send_byte(8'h01, 1'b1, "R1 silent after miss");
    bus_stop();

    // R2 / R4: inversion register and input view
    write_reg(8'h02, 8'hF0, "R2 write inversion");
    read_reg(8'h00, 1, 8'hAA, "R4 input xor inversion");

    // R3: several data bytes into one register
    bus_start();
    send_byte(AW, 1'b0, "R2 addr ack");
    send_byte(8'h01, 1'b0, "R2 cmd ack");
    send_byte(8'hA5, 1'b0, "R3 data1 ack");
    send_byte(8'h3C, 1'b0, "R3 data2 ack");
    bus_stop();
    chk("R3 last byte kept", drv, 8'h3C);
    read_reg(8'h02, 1, 8'hF0, "R3 neighbour untouched");
    read_reg(8'h01, 3, 8'h3C, "R3 streamed read");

    // R7: pointer survives a stop
    bus_start();
    send_byte(AR, 1'b0, "R7 addr ack");
    recv_byte(8'h3C, "R7 pointer kept", 1'b0);
    bus_stop();

    // R4: input register ignores writes; direction register
    write_reg(8'h00, 8'h12, "R4 write input");
    read_reg(8'h00, 1, 8'hAA, "R4 input read-only");
    write_reg(8'h03, 8'h0F, "R4 write direction");
    chk("R4 direction out", isin, 8'h0F);

    // R5: out-of-range pointer
    write_reg(8'h07, 8'h55, "R5 out of range");
    read_reg(8'h07, 1, 8'h00, "R5 reads zero");
    read_reg(8'h01, 1, 8'h3C, "R5 drive unchanged");
    read_reg(8'h03, 1, 8'h0F, "R5 direction unchanged");

    // R9: stop in the middle of a data byte
    bus_start();
    send_byte(AW, 1'b0, "R9 addr ack");
    send_byte(8'h01, 1'b0, "R9 cmd ack");
    send_bit(1'b0); send_bit(1'b1); send_bit(1'b0); send_bit(1'b1);
    bus_stop();
    chk("R9 partial byte dropped", drv, 8'h3C);
    chk("R9 sda released", {7'd0, sda_pull}, 8'h00);
    read_reg(8'h01, 1, 8'h3C, "R9 usable after stop");

    // R8: after a master NACK the line stays released
    bus_start();
    send_byte(AW, 1'b0, "R8 addr ack");
    send_byte(8'h02, 1'b0, "R8 cmd ack");
    bus_start();
    send_byte(AR, 1'b0, "R8 read addr ack");
    recv_byte(8'hF0, "R8 last byte", 1'b0);
    recv_byte(8'hFF, "R8 released after nack", 1'b0);
    bus_stop();

    // R10: each byte captured at its acknowledge edge
    write_reg(8'h02, 8'h00, "R10 clear inversion");
    pins = 8'h11;
    repeat (10) @(negedge clk);
    bus_start();
    send_byte(AW, 1'b0, "R10 addr ack");
    send_byte(8'h00, 1'b0, "R10 cmd ack");
    bus_start();
    send_byte(AR, 1'b0, "R10 read addr ack");
    pins = 8'h22;
    recv_byte(8'h11, "R10 first byte", 1'b1);
    recv_byte(8'h22, "R10 second byte", 1'b0);
    bus_stop();

    // R11: interrupt behaviour, direction = 0Fh
    bus_start();
    send_byte(AR, 1'b0, "R11 addr ack");
    recv_byte(8'h22, "R11 input read", 1'b0);
    bus_stop();
    chk("R11 released after input read", {7'd0, irq_n}, 8'h01);
    pins = 8'hA2;
    repeat (10) @(negedge clk);
    chk("R11 output pin change ignored", {7'd0, irq_n}, 8'h01);
    pins = 8'hA3;
    repeat (10) @(negedge clk);
    chk("R11 input pin change raises", {7'd0, irq_n}, 8'h00);
    read_reg(8'h01, 1, 8'h3C, "R11 other register read");
    chk("R11 other read keeps irq", {7'd0, irq_n}, 8'h00);
    read_reg(8'h00, 1, 8'hA3, "R11 clearing read");
    chk("R11 released", {7'd0, irq_n}, 8'h01);

    repeat (50) @(negedge clk);
    chk("R3 scoreboard drained", 8'(sb_q.size()), 8'h00);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
      $finish;
    end
  end

endmodule